// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block arbitrates among eight interrupt request lines for a processor. Requests are collected in a pending register. Each line can be masked. Lines that are being serviced are tracked in an in-service register. A three-bit priority pointer chooses which line is examined first. The scan starts at the pointer and moves upward, wrapping from line 7 back to line 0. The scan covers both pending and in-service lines, so a line already in service keeps lines behind it in scan order waiting.

Software controls the block through a byte-wide write port with a two-bit address. Address 0 carries commands: initialise, end-of-service with optional pointer rotation, and read-select / special-mask-mode control. The other addresses load the mask, the vector base and the cascade mask directly. Lines marked in the cascade mask belong to a downstream controller. They take part in the scan but are never granted here.

When a grant is possible and the processor has interrupts enabled, `int_o` is raised and `vector_o` presents the vector. The processor answers with `ack_i`. In that cycle the granted line moves from pending to in service.

Top module: `pirc_top`

## Requirements
- R1: After a synchronous reset:
  - mask = 7Dh, cascade mask = 80h, vector base = 08h.
  - Pointer 0, pending 00h, in-service 00h.
  - Read-select 0 and special mask mode off.
- R2: Writes are decoded by `wr_addr_i`:
  - 0 is a command.
  - 1 loads the mask.
  - 2 loads the vector base.
  - 3 loads the cascade mask.
- R3: A command with bit 4 set is an initialise. It clears the mask, pending register, read-select, special mask mode and pointer. The in-service register is left unchanged.
- R4: A command with bits 4:3 = 00 is an end-of-service command. With bit 6 set, its target is bits 2:0. Otherwise its target is the first in-service line found scanning upward from the pointer, modulo 8. With no in-service line and bit 6 clear, the command has no effect.
- R5: In an end-of-service command, bit 7 set loads the pointer with target+1 modulo 8. Bit 5 set clears the target's in-service bit. Both may act in one write.
- R6: A command with bits 4:3 = 01 is a mode command:
  - Bit 0 becomes the read-select only if bit 1 is set.
  - Bit 5 becomes special mask mode only if bit 6 is set.
  - Otherwise each keeps its value.
- R7: `rd_data_o` shows the pending register when read-select is 0 and the in-service register when it is 1.
- R8: Candidates are pending, unmasked, not-in-service lines. A grant exists only when the first line found from the pointer, over candidates plus blocking in-service lines, is a candidate.
- R9: Blocking in-service lines:
  - In normal mode, every in-service line blocks.
  - In special mask mode, only in-service lines that are also masked block.
- R10: When `ack_i` is high while `int_o` is high:
  - The granted line's in-service bit is set and its pending bit is cleared.
  - `vector_o` = (base AND F8h) OR level.
  - `int_o` falls the next cycle if no other grant exists.
- R11: With `int_en_i` low, `int_o` stays low and `ack_i` has no effect.
- R12: A line set in the cascade mask is never granted, though a pending one still blocks lines after it in scan order.
- R13: Each cycle `req_i` is ORed into the pending register after all other updates. An `ack_i` in a cycle with `wr_en_i` high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request lines, latched into pending register |
| int_en_i | input | 1 | Processor interrupt enable |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write target: 0 command, 1 mask, 2 base, 3 cascade |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Pending or in-service register, per read-select |
| int_o | output | 1 | Interrupt to processor |
| ack_i | input | 1 | Processor acknowledge |
| vector_o | output | 8 | Vector of the line that would be granted |

## Verification
A wrong pending or in-service bit shows up at the ports in the same cycle as a wrong `int_o` or `vector_o`. A wrong pointer cannot be seen directly. It appears only when two lines compete, or when a non-specific end-of-service command picks its target. The bench therefore keeps competing lines pending around every rotation. Wrong read-select or special-mask state appears on `rd_data_o` or in blocking on the next cycle. The reference model compares `int_o`, `vector_o` and `rd_data_o` on every clock, so any divergence is reported in the cycle it becomes visible.

// File: rtl/pirc_pkg.sv
package pirc_pkg;

    localparam int unsigned PIRC_LINES = 8;
    localparam int unsigned PIRC_LW    = $clog2(PIRC_LINES);

    typedef enum logic [1:0] {
        WA_CMD  = 2'd0,
        WA_MASK = 2'd1,
        WA_BASE = 2'd2,
        WA_CASC = 2'd3
    } pirc_waddr_e;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_INIT,
        CK_EOS,
        CK_MODE
    } pirc_kind_e;

    typedef struct packed {
        pirc_kind_e              kind;
        logic                    specific;
        logic                    rotate;
        logic                    clr_isr;
        logic [PIRC_LW-1:0]      lvl;
        logic                    rs_we;
        logic                    rs_val;
        logic                    smm_we;
        logic                    smm_val;
        logic                    ld_mask;
        logic                    ld_base;
        logic                    ld_casc;
        logic [PIRC_LINES-1:0]   payload;
    } pirc_cmd_t;

    typedef struct packed {
        logic               hit;
        logic [PIRC_LW-1:0] lvl;
    } pirc_pick_t;

endpackage

// File: rtl/pirc_scan.sv
// Rotating first-set finder: scans upward from start, wrapping modulo N.
module pirc_scan
    import pirc_pkg::*;
#(
    parameter int unsigned N  = PIRC_LINES,
    parameter int unsigned LW = PIRC_LW
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] start,
    output pirc_pick_t    pick
);

    always_comb begin
        pick = '0;
        // Descending offset so the smallest offset from start wins last.
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(start) + k) % N;
            if (vec[idx]) begin
                pick.hit = 1'b1;
                pick.lvl = idx[LW-1:0];
            end
        end
    end

endmodule

// File: rtl/pirc_cmd_dec.sv
// Turns one write into a command descriptor (R2, R3, R4, R6).
module pirc_cmd_dec
    import pirc_pkg::*;
(
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output pirc_cmd_t   cmd
);

    always_comb begin
        cmd          = '0;
        cmd.specific = wr_data[6];
        cmd.rotate   = wr_data[7];
        cmd.clr_isr  = wr_data[5];
        cmd.lvl      = wr_data[PIRC_LW-1:0];
        cmd.rs_we    = wr_data[1];
        cmd.rs_val   = wr_data[0];
        cmd.smm_we   = wr_data[6];
        cmd.smm_val  = wr_data[5];
        cmd.payload  = wr_data;
        if (wr_en) begin
            unique case (pirc_waddr_e'(wr_addr))
                WA_CMD: begin
                    if (wr_data[4])      cmd.kind = CK_INIT;  // R3
                    else if (wr_data[3]) cmd.kind = CK_MODE;  // R6
                    else                 cmd.kind = CK_EOS;   // R4
                end
                WA_MASK: cmd.ld_mask = 1'b1;
                WA_BASE: cmd.ld_base = 1'b1;
                WA_CASC: cmd.ld_casc = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pirc_top.sv
module pirc_top
    import pirc_pkg::*;
#(
    parameter logic [PIRC_LINES-1:0] RST_MASK = 8'h7D,
    parameter logic [PIRC_LINES-1:0] RST_CASC = 8'h80,
    parameter logic [PIRC_LINES-1:0] RST_BASE = 8'h08
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_i,
    input  logic       int_en_i,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    output logic       int_o,
    input  logic       ack_i,
    output logic [7:0] vector_o
);

    localparam int unsigned N  = PIRC_LINES;
    localparam int unsigned LW = PIRC_LW;

    logic [N-1:0]  irr_q, isr_q, imr_q, casc_q, base_q;
    logic [LW-1:0] ptr_q;
    logic          rsel_q, smm_q;

    logic [N-1:0]  irr_d, isr_d, imr_d, casc_d, base_d;
    logic [LW-1:0] ptr_d;
    logic          rsel_d, smm_d;

    pirc_cmd_t     cmd;
    pirc_pick_t    arb_pick, eos_pick;
    logic [N-1:0]  cand, blk;
    logic          grant_ok, take;
    logic [LW-1:0] eos_lvl;
    logic          eos_valid;

    pirc_cmd_dec u_dec (
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .cmd     (cmd)
    );

    // R8, R9: candidates and blocking in-service lines
    assign cand = irr_q & ~imr_q & ~isr_q;
    assign blk  = smm_q ? (isr_q & imr_q) : isr_q;

    pirc_scan #(.N(N), .LW(LW)) u_arb (
        .vec   (cand | blk),
        .start (ptr_q),
        .pick  (arb_pick)
    );

    pirc_scan #(.N(N), .LW(LW)) u_eos (
        .vec   (isr_q),
        .start (ptr_q),
        .pick  (eos_pick)
    );

    // R8, R12: grant only a non-cascade candidate found first
    assign grant_ok  = arb_pick.hit && cand[arb_pick.lvl] && !casc_q[arb_pick.lvl];
    assign int_o     = int_en_i && grant_ok;                  // R11
    assign vector_o  = {base_q[N-1:LW], arb_pick.lvl};        // R10
    assign take      = ack_i && int_o && !wr_en_i;            // R13
    assign rd_data_o = rsel_q ? isr_q : irr_q;                // R7

    // R4: end-of-service target
    assign eos_lvl   = cmd.specific ? cmd.lvl : eos_pick.lvl;
    assign eos_valid = cmd.specific || eos_pick.hit;

    always_comb begin
        irr_d  = irr_q;
        isr_d  = isr_q;
        imr_d  = imr_q;
        casc_d = casc_q;
        base_d = base_q;
        ptr_d  = ptr_q;
        rsel_d = rsel_q;
        smm_d  = smm_q;

        if (take) begin                                       // R10
            isr_d[arb_pick.lvl] = 1'b1;
            irr_d[arb_pick.lvl] = 1'b0;
        end

        unique case (cmd.kind)
            CK_INIT: begin                                    // R3
                imr_d  = '0;
                irr_d  = '0;
                rsel_d = 1'b0;
                smm_d  = 1'b0;
                ptr_d  = '0;
            end
            CK_EOS: begin                                     // R5
                if (eos_valid) begin
                    if (cmd.rotate)  ptr_d = eos_lvl + 1'b1;
                    if (cmd.clr_isr) isr_d[eos_lvl] = 1'b0;
                end
            end
            CK_MODE: begin                                    // R6
                if (cmd.rs_we)  rsel_d = cmd.rs_val;
                if (cmd.smm_we) smm_d  = cmd.smm_val;
            end
            default: ;
        endcase

        if (cmd.ld_mask) imr_d  = cmd.payload;                // R2
        if (cmd.ld_base) base_d = cmd.payload;
        if (cmd.ld_casc) casc_d = cmd.payload;

        irr_d = irr_d | req_i;                                // R13
    end

    always_ff @(posedge clk) begin
        if (rst) begin                                        // R1
            irr_q  <= '0;
            isr_q  <= '0;
            imr_q  <= RST_MASK;
            casc_q <= RST_CASC;
            base_q <= RST_BASE;
            ptr_q  <= '0;
            rsel_q <= 1'b0;
            smm_q  <= 1'b0;
        end else begin
            irr_q  <= irr_d;
            isr_q  <= isr_d;
            imr_q  <= imr_d;
            casc_q <= casc_d;
            base_q <= base_d;
            ptr_q  <= ptr_d;
            rsel_q <= rsel_d;
            smm_q  <= smm_d;
        end
    end

endmodule

// File: rtl/pirc_chk.sv
module pirc_chk
    import pirc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  int_en_i,
    input logic                  ack_i,
    input logic                  wr_en_i,
    input logic [1:0]            wr_addr_i,
    input logic [7:0]            wr_data_i,
    input logic                  int_o,
    input logic [7:0]            vector_o,
    input logic [PIRC_LINES-1:0] irr_q,
    input logic [PIRC_LINES-1:0] isr_q,
    input logic [PIRC_LINES-1:0] imr_q,
    input logic [PIRC_LINES-1:0] casc_q,
    input logic [PIRC_LW-1:0]    ptr_q
);

    logic is_init;
    assign is_init = wr_en_i && (wr_addr_i == 2'd0) && wr_data_i[4];

    AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_i && int_o && !wr_en_i) |=> isr_q[$past(vector_o[PIRC_LW-1:0])]); // R10

    AST_NO_CASCADE_GRANT: assert property (@(posedge clk) disable iff (rst)
        int_o |-> !casc_q[vector_o[PIRC_LW-1:0]]); // R12

    AST_GRANT_IS_CANDIDATE: assert property (@(posedge clk) disable iff (rst)
        int_o |-> (irr_q[vector_o[PIRC_LW-1:0]] && !imr_q[vector_o[PIRC_LW-1:0]]
                   && !isr_q[vector_o[PIRC_LW-1:0]])); // R8

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        is_init |=> (imr_q == '0 && ptr_q == '0)); // R3

    AST_INIT_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        is_init |=> (isr_q == $past(isr_q))); // R3

    AST_DISABLED_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!int_en_i && ack_i && !wr_en_i) |=> (isr_q == $past(isr_q))); // R11

endmodule

bind pirc_top pirc_chk u_chk (.*);

// File: tb/sim_pirc_top.sv
module sim_pirc_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       int_en_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       ack_i = 1'b0;
    logic [7:0] rd_data_o, vector_o;
    logic       int_o;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference model state
    bit [7:0] m_irr, m_isr, m_imr, m_casc, m_base;
    int       m_ptr;
    bit       m_rs, m_smm;

    always #(CLK_PERIOD/2) clk = ~clk;

    pirc_top u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .int_en_i(int_en_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .int_o(int_o), .ack_i(ack_i), .vector_o(vector_o)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", cur_req, what, act, exp);
        end
    endtask

    function automatic int first_from(input bit [7:0] v, input int s);
        for (int k = 0; k < 8; k++) begin
            if (v[(s + k) % 8]) return (s + k) % 8;
        end
        return -1;
    endfunction

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_imr = 8'h7D; m_casc = 8'h80; m_base = 8'h08;
        m_ptr = 0; m_rs = 0; m_smm = 0;
    endtask

    // one cycle: drive, compare against model, advance model at the edge
    task automatic step(input bit [7:0] req, input bit en, input bit ack,
                        input bit wr, input bit [1:0] a, input bit [7:0] d);
        bit [7:0] cand, blk, n_irr, n_isr, n_imr, n_casc, n_base;
        int f, tgt, n_ptr;
        bit ok, eint, n_rs, n_smm;
        req_i = req; int_en_i = en; ack_i = ack; wr_en_i = wr; wr_addr_i = a; wr_data_i = d;
        #1;
        cand = m_irr & ~m_imr & ~m_isr;
        blk  = m_smm ? (m_isr & m_imr) : m_isr;
        f    = first_from(cand | blk, m_ptr);
        ok   = (f >= 0) && cand[f] && !m_casc[f];
        eint = en && ok;
        chk("int_o", {7'b0, int_o}, {7'b0, eint});
        if (eint) chk("vector_o", vector_o, (m_base & 8'hF8) | 8'(f));
        chk("rd_data_o", rd_data_o, m_rs ? m_isr : m_irr);

        n_irr = m_irr; n_isr = m_isr; n_imr = m_imr; n_casc = m_casc; n_base = m_base;
        n_ptr = m_ptr; n_rs = m_rs; n_smm = m_smm;
        if (ack && eint && !wr) begin
            n_isr[f] = 1'b1;
            n_irr[f] = 1'b0;
        end
        if (wr) begin
            case (a)
                2'd0: begin
                    if (d[4]) begin
                        n_imr = 0; n_irr = 0; n_rs = 0; n_smm = 0; n_ptr = 0;
                    end else if (d[3]) begin
                        if (d[1]) n_rs = d[0];
                        if (d[6]) n_smm = d[5];
                    end else begin
                        tgt = d[6] ? int'(d[2:0]) : first_from(m_isr, m_ptr);
                        if (tgt >= 0) begin
                            if (d[7]) n_ptr = (tgt + 1) % 8;
                            if (d[5]) n_isr[tgt] = 1'b0;
                        end
                    end
                end
                2'd1: n_imr = d;
                2'd2: n_base = d;
                default: n_casc = d;
            endcase
        end
        n_irr = n_irr | req;
        @(posedge clk);
        m_irr = n_irr; m_isr = n_isr; m_imr = n_imr; m_casc = n_casc; m_base = n_base;
        m_ptr = n_ptr; m_rs = n_rs; m_smm = n_smm;
        @(negedge clk);
    endtask

    task automatic nop();                                step(0, 1, 0, 0, 0, 0); endtask
    task automatic rq(input bit [7:0] m);                step(m, 1, 0, 0, 0, 0); endtask
    task automatic ak();                                 step(0, 1, 1, 0, 0, 0); endtask
    task automatic wr(input bit [1:0] a, input bit [7:0] d); step(0, 1, 0, 1, a, d); endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        nop();
        chk("reset rd", rd_data_o, 8'h00);
        rq(8'h02);
        nop();
        chk("reset vector", vector_o, 8'h09);

        cur_req = "R10";
        ak(); nop();
        cur_req = "R7";
        wr(0, 8'h0B);
        chk("isr read", rd_data_o, 8'h02);

        cur_req = "R5";
        wr(0, 8'h20); nop();
        chk("eoi clears", rd_data_o, 8'h00);

        cur_req = "R2";
        wr(1, 8'h00); wr(2, 8'h40); wr(3, 8'h00);

        cur_req = "R8";
        rq(8'h28); nop();
        chk("lowest first", vector_o, 8'h43);
        ak(); nop(); nop();
        wr(0, 8'h20); nop(); ak();

        cur_req = "R5";
        wr(0, 8'hA0);
        rq(8'h84); nop(); ak(); nop(); ak(); nop();
        cur_req = "R4";
        wr(0, 8'h67); wr(0, 8'h62); wr(0, 8'h20); wr(0, 8'hA0); nop();

        cur_req = "R6";
        wr(0, 8'h09); nop(); wr(0, 8'h0A); nop();
        wr(0, 8'h28); wr(0, 8'h68);

        cur_req = "R9";
        rq(8'h01); ak(); rq(8'h02); nop();
        wr(1, 8'h01); nop();
        wr(0, 8'h48); nop();
        wr(1, 8'h00); nop();
        wr(0, 8'h60); nop(); ak(); wr(0, 8'h61); nop();

        cur_req = "R12";
        wr(3, 8'h04); rq(8'h04); nop(); rq(8'h08); nop();
        wr(3, 8'h00); nop(); ak(); nop(); ak(); wr(0, 8'h20); wr(0, 8'h20);

        cur_req = "R11";
        step(8'h10, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        nop();

        cur_req = "R13";
        step(0, 1, 1, 1, 2'd2, 8'h40);
        nop(); ak(); nop();
        wr(0, 8'h20);

        cur_req = "R3";
        rq(8'h40); wr(0, 8'h0B); wr(0, 8'h10); nop();
        wr(0, 8'h0B); nop();

        cur_req = "R8 random";
        for (int i = 0; i < 3000; i++) begin
            bit [7:0] rm;
            rm = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            step(rm, ($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 6) == 0,
                 2'($urandom % 4), 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule